// File: doc/BRIEF.md
# Sixteen-bit multiply unit with flags

This block multiplies two 16-bit integers for a small processor core and reports the result together with a set of status flags. A two-bit operation code picks one of three forms. The first is an unsigned multiply that gives a 32-bit product split into a high and a low half. The second is a signed multiply that gives a 32-bit product split the same way. The third is a signed multiply that keeps only the low 16 bits.

The unit is iterative. A start strobe is accepted only while the unit is idle. The operands are then reduced to magnitudes and run through sixteen shift-add steps. The sign is restored in the last step, and the results and flags are registered together with a one-cycle done pulse. The outputs hold their values until the next completion. The zero, sign and parity flags come from the low half alone, and the auxiliary flag is always cleared. Overflow and carry are always equal, and the rule that sets them depends on the operation form.

Top module: `mul16_flags`

## Requirements
- R1: With op = 2'b00, {res_hi, res_lo} is the unsigned 32-bit product of opnd_a and opnd_b.
- R2: With op = 2'b01, {res_hi, res_lo} is the two's-complement 32-bit product of the sign-extended operands.
- R3: With op = 2'b10 or 2'b11, res_lo is the low 16 bits of the signed product and res_hi is zero.
- R4: flags is {OF, SF, ZF, AF, PF, CF} from bit 5 down to bit 0. SF (bit 4) equals res_lo bit 15, ZF (bit 3) is set when res_lo is zero, and AF (bit 2) is always 0.
- R5: PF (bit 1) is set when bits 7:0 of res_lo hold an even number of ones.
- R6: With op = 2'b00, OF (bit 5) and CF (bit 0) are both set exactly when the high half of the product is nonzero.
- R7: With any signed op, OF and CF are both set exactly when the 32-bit signed product differs from the sign extension of its own low 16 bits.
- R8: done is high for exactly one cycle, 16 clock cycles after the edge that accepts start, and busy is low in that cycle.
- R9: A start seen while busy is high is ignored: it causes no extra done pulse and does not change the running result.
- R10: res_hi, res_lo and flags change only in a cycle where done is high.
- R11: After reset, busy, done, res_hi, res_lo and flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | 00 unsigned widening, 01 signed widening, 1x signed truncating |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_hi | output | 16 | High half of the product (zero for truncating form) |
| res_lo | output | 16 | Low half of the product |
| flags | output | 6 | {OF, SF, ZF, AF, PF, CF} |

## Verification
The hardest situations to reach from the ports are a start that arrives while an operation is already running, and a new start issued in the very cycle the previous done appears. The driver handles the first by raising start with different operands partway through an operation and expecting only the first result. It handles the second by issuing each request as soon as busy falls, so requests run back to back. The sign corners are driven on purpose: -32768 times itself, -32768 times -1, and all-ones in both the signed and unsigned forms. In these cases the magnitude path and the sign-extension overflow test give different answers than their naive forms.

// File: rtl/mul16_flags.sv
`timescale 1ns/1ps
module mul16_flags #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo,
  output logic [5:0]   flags
);
  localparam int W2 = 2 * W;
  localparam int CW = $clog2(W);

  logic [CW-1:0] cnt;
  logic [W-1:0]  mcand;
  logic [W2-1:0] prod;
  logic          neg;
  logic [1:0]    op_q;

  wire          sgn_op = |op;
  wire [W-1:0]  mag_a  = (sgn_op && opnd_a[W-1]) ? (~opnd_a + 1'b1) : opnd_a;
  wire [W-1:0]  mag_b  = (sgn_op && opnd_b[W-1]) ? (~opnd_b + 1'b1) : opnd_b;

  wire [W:0]    sum    = {1'b0, prod[W2-1:W]} + (prod[0] ? {1'b0, mcand} : {(W+1){1'b0}});
  wire [W2-1:0] step   = {sum, prod[W-1:1]};
  wire [W2-1:0] fin    = neg ? (~step + 1'b1) : step;
  wire [W-1:0]  fin_hi = fin[W2-1:W];
  wire [W-1:0]  fin_lo = fin[W-1:0];
  wire          ovf    = (op_q == 2'b00) ? (|fin_hi) : (fin_hi != {W{fin_lo[W-1]}});
  wire          last   = busy && (cnt == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      mcand  <= '0;
      prod   <= '0;
      neg    <= 1'b0;
      op_q   <= 2'b00;
      res_hi <= '0;
      res_lo <= '0;
      flags  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          cnt   <= '0;
          op_q  <= op;
          neg   <= sgn_op & (opnd_a[W-1] ^ opnd_b[W-1]);
          mcand <= mag_a;
          prod  <= {{W{1'b0}}, mag_b};
        end
      end else begin
        prod <= step;
        cnt  <= cnt + 1'b1;
        if (last) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          res_hi <= op_q[1] ? {W{1'b0}} : fin_hi;
          res_lo <= fin_lo;
          flags  <= {ovf, fin_lo[W-1], ~|fin_lo, 1'b0, ~^fin_lo[7:0], ovf};
        end
      end
    end
  end
endmodule

// File: rtl/mul16_flags_chk.sv
`timescale 1ns/1ps
module mul16_flags_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] res_hi,
  input logic [W-1:0] res_lo,
  input logic [5:0]   flags
);
  localparam int W2 = 2 * W;
  localparam int LW = $clog2(W) + 1;

  logic [1:0]    op_l;
  logic [W-1:0]  a_l, b_l;
  logic [LW-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_l <= 2'b00;
      a_l  <= '0;
      b_l  <= '0;
      lat  <= '0;
    end else if (!busy && start) begin
      op_l <= op;
      a_l  <= opnd_a;
      b_l  <= opnd_b;
      lat  <= '0;
    end else if (busy) begin
      lat <= lat + 1'b1;
    end
  end

  wire [W2-1:0] gu = {{W{1'b0}}, a_l} * {{W{1'b0}}, b_l};
  wire [W2-1:0] gs = $signed({{W{a_l[W-1]}}, a_l}) * $signed({{W{b_l[W-1]}}, b_l});

  a_r1_unsigned_product: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_l == 2'b00) |-> ({res_hi, res_lo} == gu));
  a_r2_signed_product: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_l == 2'b01) |-> ({res_hi, res_lo} == gs));
  a_r3_truncated: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_l[1]) |-> (res_hi == '0 && res_lo == gs[W-1:0]));
  a_r4_low_flags: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags[4] == res_lo[W-1] && flags[3] == (res_lo == '0) && !flags[2]));
  a_r5_parity: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags[1] == ~^res_lo[7:0]));
  a_r6_unsigned_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_l == 2'b00) |-> (flags[5] == (gu[W2-1:W] != '0) && flags[0] == flags[5]));
  a_r7_signed_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_l != 2'b00) |-> (flags[5] == (gs[W2-1:W] != {W{gs[W-1]}}) && flags[0] == flags[5]));
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat == LW'(W) && !busy));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({res_hi, res_lo, flags}));
endmodule

bind mul16_flags mul16_flags_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo), .flags(flags)
);

// File: tb/test_mul16_flags.sv
`timescale 1ns/1ps
module test_mul16_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [15:0] opnd_a = '0, opnd_b = '0;
  logic        busy, done;
  logic [15:0] res_hi, res_lo;
  logic [5:0]  flags;

  always #2 clk = ~clk;

  mul16_flags i_mul16_flags (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo), .flags(flags)
  );

  typedef struct {
    logic [15:0] hi;
    logic [15:0] lo;
    logic [5:0]  fl;
    int          due;
    string       req;
  } exp_t;

  exp_t sb[$];
  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] last_hi = '0, last_lo = '0;
  logic [5:0]  last_fl = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [1:0] o, input logic [15:0] x, input logic [15:0] y);
    exp_t e;
    logic [31:0] p;
    logic ov;
    if (o == 2'b00) begin
      p  = {16'b0, x} * {16'b0, y};
      ov = (p[31:16] != 16'h0);
    end else begin
      p  = $signed({{16{x[15]}}, x}) * $signed({{16{y[15]}}, y});
      ov = (p[31:16] != {16{p[15]}});
    end
    e.hi  = o[1] ? 16'h0 : p[31:16];
    e.lo  = p[15:0];
    e.fl  = {ov, p[15], (p[15:0] == 16'h0), 1'b0, ~^p[7:0], ov};
    e.due = 0;
    e.req = (o == 2'b00) ? "R1/R6" : (o == 2'b01) ? "R2/R7" : "R3/R7";
    return e;
  endfunction

  task automatic issue(input logic [1:0] o, input logic [15:0] x, input logic [15:0] y);
    exp_t e;
    while (busy) @(negedge clk);
    e = model(o, x, y);
    e.due = cyc + 17;
    sb.push_back(e);
    op = o; opnd_a = x; opnd_b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R9", "unexpected done", 32'(done), 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk({res_hi, res_lo} == {e.hi, e.lo}, e.req, "product", {res_hi, res_lo}, {e.hi, e.lo});
          chk(flags[4:1] == e.fl[4:1], "R4/R5", "SF ZF AF PF", 32'(flags), 32'(e.fl));
          chk(flags[5] == e.fl[5] && flags[0] == e.fl[0], e.req, "OF CF", 32'(flags), 32'(e.fl));
          chk(cyc == e.due && !busy, "R8", "done cycle", 32'(cyc), 32'(e.due));
        end
        last_hi = res_hi; last_lo = res_lo; last_fl = flags;
      end else begin
        chk({res_hi, res_lo, flags} == {last_hi, last_lo, last_fl}, "R10", "held outputs",
            {res_hi, res_lo}, {last_hi, last_lo});
      end
    end
  end

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, res_hi, res_lo, flags} == '0, "R11", "reset state",
        {res_hi, res_lo}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R11", "idle after reset", 32'({busy, done}), 32'd0);

    issue(2'b00, 16'd3, 16'd5);
    issue(2'b00, 16'hFFFF, 16'hFFFF);     // R6 overflow set
    issue(2'b01, 16'hFFFF, 16'hFFFF);     // R7: -1 * -1 fits
    issue(2'b01, 16'h8000, 16'h8000);     // R2 extreme
    issue(2'b01, 16'h8000, 16'hFFFF);     // R7: +32768 does not fit
    issue(2'b10, 16'h7FFF, 16'h0002);     // R3 truncation with overflow
    issue(2'b11, 16'hFFFE, 16'h0003);     // R3 negative, fits
    issue(2'b00, 16'h0100, 16'h0100);     // R4 ZF with R6 overflow
    issue(2'b01, 16'h0000, 16'h8000);     // R4 zero, signs differ
    issue(2'b00, 16'h0000, 16'h0000);

    // R9: start while busy with other operands must be ignored
    issue(2'b00, 16'h1234, 16'h0010);
    repeat (3) @(negedge clk);
    op = 2'b01; opnd_a = 16'hAAAA; opnd_b = 16'h5555; start = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;

    for (int k = 0; k < 60; k++) begin
      issue(2'($urandom_range(0, 3)), 16'($urandom), 16'($urandom));
    end

    while (busy || sb.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R9", "pending results", 32'(sb.size()), 32'd0);
    summary();
  end
endmodule